// File: doc/BRIEF.md
# Adaptive Dwell Timing Controller

This block decides, once per engine cycle, when the ignition coil starts charging and when it is released to fire the spark. It watches an already filtered zero-cross signal from the crank position sensor. It drives a single coil-enable output towards an external current driver. Two saturating up/down counters stand in for timing capacitors.

The ramp counter measures the engine period. It falls quickly during a short "quarter" phase that opens on each rising zero-cross edge. It climbs slowly for the rest of the cycle, the "three-quarter" phase. The adaptive counter is the turn-on threshold. The coil is enabled once the ramp climbs past it.

The threshold sinks during each quarter phase. It grows only after the current limiter reports a full coil, so it settles where the coil reaches its limit a fixed fraction of the cycle before the spark. A start flag pins the threshold at zero for maximum dwell. A high-supply flag slows its decay. An overvoltage flag overrides everything and keeps the coil off. Fractional rates come from per-counter phase accumulators that step the counter whenever they overflow.

Top module: `adt_dwell_ctrl`

## Requirements
- R1: While the synchronised reset is active, and in the reset state it leaves behind, the coil output is low, both counters are zero and the phase is three-quarter. The reset is asserted at once. Its release reaches the logic two clock edges after `rst_n` rises.
- R2: A rising edge of `zc_in`, seen as high in a cycle after low in the previous cycle, starts the quarter phase. On the same clock edge the coil output goes low, which is the spark.
- R3: Each clock, a counter's accumulator adds the active increment, in units of 1/2^FRAC_W. The counter moves one step on each accumulator overflow, and the remainder is carried across phase changes. The ramp counter steps down with increment RAMP_DN_INC in the quarter phase and up with RAMP_UP_INC in the three-quarter phase. The default DN increment is four times the UP increment.
- R4: A quarter phase whose ramp counter is at or below REF_LEVEL at a clock edge switches to three-quarter at that edge, unless that edge also carries a new rising zero-cross.
- R5: In the quarter phase the adaptive counter steps down with ADP_DN_INC. It uses ADP_DN_HI_INC instead while `hi_supply` is 1.
- R6: In the three-quarter phase the adaptive counter and its accumulator hold until `cur_lim` has been seen high while the coil is on. From the next clock until the next rising zero-cross, it steps up with ADP_UP_INC.
- R7: In the three-quarter phase, the coil output goes high on the first clock edge at which the ramp counter is greater than the adaptive counter. It then stays high until a rising zero-cross or overvoltage.
- R8: While `start_mode` is 1, the adaptive counter and its accumulator are cleared on every clock.
- R9: A clock edge with `ovp` at 1 leaves the coil output low, whatever the other inputs are.
- R10: Neither counter wraps. A step down at zero and a step up at 2^CNT_W-1 leave the value unchanged.
- R11: A zero-cross held high for many cycles starts only one quarter phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| zc_in | input | 1 | Filtered zero-cross level; its rising edge is the spark command |
| cur_lim | input | 1 | Coil current has reached the limiter threshold |
| hi_supply | input | 1 | Supply is high; selects the slow threshold decay |
| ovp | input | 1 | Overvoltage; forces the coil off |
| start_mode | input | 1 | Start mode; holds the threshold at zero |
| coil_on | output | 1 | Coil drive enable |

## Verification
The properties take for granted several things about the inputs:
- `zc_in` is already free of bounce.
- `cur_lim` only means something while the coil is on.
- Each increment stays below 2^FRAC_W, so a counter moves at most one step per clock.

The stimulus keeps to these conditions:
- It drives the zero-cross as clean square waves at several periods.
- It raises the current-limit flag a fixed number of cycles after the coil output is seen high, and drops it when the coil goes off.
- Overvoltage comes as single-cycle pulses.

A reference model built from the requirements predicts the coil output on every cycle.

// File: rtl/adt_pkg.sv
package adt_pkg;

  typedef enum logic {
    PH_75 = 1'b0,
    PH_25 = 1'b1
  } phase_e;

endpackage

// File: rtl/adt_rst_sync.sv
module adt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= 1'b1;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= 1'b0;
        else        sync_q[i] <= sync_q[i-1];
      end
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/adt_rate_cnt.sv
module adt_rate_cnt #(
  parameter int CNT_W  = 12,
  parameter int FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              up_en,
  input  logic              dn_en,
  input  logic [FRAC_W-1:0] inc,
  output logic [CNT_W-1:0]  count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [FRAC_W-1:0] acc_q, acc_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [FRAC_W:0]   acc_sum;
  logic              step;
  logic              ce;

  assign acc_sum = {1'b0, acc_q} + {1'b0, inc};
  assign step    = acc_sum[FRAC_W];
  assign ce      = clr | up_en | dn_en;

  always_comb begin
    acc_n = acc_q;
    cnt_n = cnt_q;
    if (clr) begin
      acc_n = '0;
      cnt_n = '0;
    end else if (up_en) begin
      acc_n = acc_sum[FRAC_W-1:0];
      if (step && (cnt_q != CNT_MAX)) cnt_n = cnt_q + 1'b1;
    end else if (dn_en) begin
      acc_n = acc_sum[FRAC_W-1:0];
      if (step && (cnt_q != '0)) cnt_n = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else if (ce) begin
      acc_q <= acc_n;
      cnt_q <= cnt_n;
    end
  end

  assign count = cnt_q;

endmodule

// File: rtl/adt_phase_ctl.sv
module adt_phase_ctl
  import adt_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int REF_LEVEL = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_in,
  input  logic [CNT_W-1:0] ramp_cnt,
  output logic             zc_rise,
  output logic             phase_25
);

  localparam logic [CNT_W-1:0] REF_V = CNT_W'(REF_LEVEL);

  logic   zc_q;
  phase_e ph_q, ph_n;

  assign zc_rise = zc_in & ~zc_q;

  always_comb begin
    ph_n = ph_q;
    if (zc_rise)                                 ph_n = PH_25;
    else if ((ph_q == PH_25) && (ramp_cnt <= REF_V)) ph_n = PH_75;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zc_q <= 1'b0;
      ph_q <= PH_75;
    end else begin
      zc_q <= zc_in;
      ph_q <= ph_n;
    end
  end

  assign phase_25 = (ph_q == PH_25);

endmodule

// File: rtl/adt_coil_drv.sv
module adt_coil_drv #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             zc_rise,
  input  logic             phase_25,
  input  logic             ovp,
  input  logic             cur_lim,
  input  logic [CNT_W-1:0] ramp_cnt,
  input  logic [CNT_W-1:0] adp_cnt,
  output logic             coil_on,
  output logic             lim_seen
);

  logic coil_q, coil_n;
  logic lim_q, lim_n;
  logic turn_on;

  assign turn_on = ~phase_25 & (ramp_cnt > adp_cnt);

  always_comb begin
    coil_n = coil_q;
    if (ovp || zc_rise) coil_n = 1'b0;
    else if (turn_on)   coil_n = 1'b1;
  end

  always_comb begin
    lim_n = lim_q;
    if (zc_rise)                lim_n = 1'b0;
    else if (coil_q && cur_lim) lim_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coil_q <= 1'b0;
      lim_q  <= 1'b0;
    end else begin
      coil_q <= coil_n;
      lim_q  <= lim_n;
    end
  end

  assign coil_on  = coil_q;
  assign lim_seen = lim_q;

endmodule

// File: rtl/adt_dwell_ctrl.sv
module adt_dwell_ctrl #(
  parameter int CNT_W         = 12,
  parameter int FRAC_W        = 8,
  parameter int RAMP_UP_INC   = 21,
  parameter int RAMP_DN_INC   = 84,
  parameter int ADP_UP_INC    = 21,
  parameter int ADP_DN_INC    = 15,
  parameter int ADP_DN_HI_INC = 4,
  parameter int REF_LEVEL     = 64,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic zc_in,
  input  logic cur_lim,
  input  logic hi_supply,
  input  logic ovp,
  input  logic start_mode,
  output logic coil_on
);

  localparam logic [FRAC_W-1:0] R_UP  = FRAC_W'(RAMP_UP_INC);
  localparam logic [FRAC_W-1:0] R_DN  = FRAC_W'(RAMP_DN_INC);
  localparam logic [FRAC_W-1:0] A_UP  = FRAC_W'(ADP_UP_INC);
  localparam logic [FRAC_W-1:0] A_DN  = FRAC_W'(ADP_DN_INC);
  localparam logic [FRAC_W-1:0] A_DNH = FRAC_W'(ADP_DN_HI_INC);

  logic             rst_sync_n;
  logic             zc_rise;
  logic             phase_25;
  logic             lim_seen;
  logic [CNT_W-1:0] ramp_cnt;
  logic [CNT_W-1:0] adp_cnt;
  logic [FRAC_W-1:0] ramp_inc;
  logic [FRAC_W-1:0] adp_inc;
  logic             adp_up_en;

  adt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  adt_phase_ctl #(.CNT_W(CNT_W), .REF_LEVEL(REF_LEVEL)) u_phase (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .zc_in    (zc_in),
    .ramp_cnt (ramp_cnt),
    .zc_rise  (zc_rise),
    .phase_25 (phase_25)
  );

  assign ramp_inc = phase_25 ? R_DN : R_UP;

  adt_rate_cnt #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_ramp (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (1'b0),
    .up_en (~phase_25),
    .dn_en (phase_25),
    .inc   (ramp_inc),
    .count (ramp_cnt)
  );

  assign adp_up_en = ~phase_25 & lim_seen;
  assign adp_inc   = phase_25 ? (hi_supply ? A_DNH : A_DN) : A_UP;

  adt_rate_cnt #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_adapt (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clr   (start_mode),
    .up_en (adp_up_en),
    .dn_en (phase_25),
    .inc   (adp_inc),
    .count (adp_cnt)
  );

  adt_coil_drv #(.CNT_W(CNT_W)) u_coil (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .zc_rise  (zc_rise),
    .phase_25 (phase_25),
    .ovp      (ovp),
    .cur_lim  (cur_lim),
    .ramp_cnt (ramp_cnt),
    .adp_cnt  (adp_cnt),
    .coil_on  (coil_on),
    .lim_seen (lim_seen)
  );

endmodule

// File: rtl/adt_dwell_chk.sv
module adt_dwell_chk #(
  parameter int CNT_W     = 12,
  parameter int REF_LEVEL = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             zc_rise,
  input logic             phase_25,
  input logic             ovp,
  input logic             start_mode,
  input logic             coil_on,
  input logic             lim_seen,
  input logic [CNT_W-1:0] ramp_cnt,
  input logic [CNT_W-1:0] adp_cnt
);

  localparam logic [CNT_W-1:0] MAXV  = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] REF_V = CNT_W'(REF_LEVEL);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  AST_ZC_SPARK: assert property (@(posedge clk) disable iff (!rst_n)
    zc_rise |=> (!coil_on && phase_25)); // R2

  AST_RAMP_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    phase_25 |=> (ramp_cnt <= $past(ramp_cnt))); // R3

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_cnt != $past(ramp_cnt)) |->
      ((CNT_W'(ramp_cnt - $past(ramp_cnt)) == ONE) || (CNT_W'($past(ramp_cnt) - ramp_cnt) == ONE))); // R3

  AST_PHASE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_25 && (ramp_cnt <= REF_V) && !zc_rise) |=> !phase_25); // R4

  AST_ADP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_25 && !start_mode) |=> (adp_cnt <= $past(adp_cnt))); // R5

  AST_ADP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_25 && !lim_seen && !start_mode) |=> (adp_cnt == $past(adp_cnt))); // R6

  AST_COIL_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coil_on) |-> (($past(ramp_cnt) > $past(adp_cnt)) && !$past(phase_25) && !$past(ovp))); // R7

  AST_START_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    start_mode |=> (adp_cnt == '0)); // R8

  AST_OVP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ovp |=> !coil_on); // R9

  AST_RAMP_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
    (!phase_25 && (ramp_cnt == MAXV)) |=> (ramp_cnt == MAXV)); // R10

  AST_ADP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_25 && (adp_cnt == '0)) |=> (adp_cnt == '0)); // R10

endmodule

bind adt_dwell_ctrl adt_dwell_chk #(.CNT_W(CNT_W), .REF_LEVEL(REF_LEVEL)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .zc_rise    (zc_rise),
  .phase_25   (phase_25),
  .ovp        (ovp),
  .start_mode (start_mode),
  .coil_on    (coil_on),
  .lim_seen   (lim_seen),
  .ramp_cnt   (ramp_cnt),
  .adp_cnt    (adp_cnt)
);

// File: tb/adt_dwell_ctrl_test.sv
`timescale 1ns/1ps
module adt_dwell_ctrl_test;

  localparam int CW   = 6;
  localparam int FW   = 5;
  localparam int RUP  = 4;
  localparam int RDN  = 16;
  localparam int AUP  = 4;
  localparam int ADN  = 3;
  localparam int ADNH = 1;
  localparam int REFL = 2;
  localparam int CMAX = (1 << CW) - 1;
  localparam int FMOD = 1 << FW;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic zc = 1'b0, cur_lim = 1'b0, hi = 1'b0, ovp = 1'b0, st = 1'b0;
  logic coil_on;

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";
  int lim_dly = 5;
  int coil_run = 0;
  bit pend_ovp = 0, pend_rise = 0;
  int model_on_cycles = 0;

  always #10 clk = ~clk;

  adt_dwell_ctrl #(
    .CNT_W(CW), .FRAC_W(FW), .RAMP_UP_INC(RUP), .RAMP_DN_INC(RDN),
    .ADP_UP_INC(AUP), .ADP_DN_INC(ADN), .ADP_DN_HI_INC(ADNH), .REF_LEVEL(REFL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .zc_in(zc), .cur_lim(cur_lim), .hi_supply(hi),
    .ovp(ovp), .start_mode(st), .coil_on(coil_on)
  );

  // reference model of the requirements
  logic [1:0] m_sync = 2'b00;
  int m_ramp = 0, m_racc = 0, m_adp = 0, m_aacc = 0;
  int m_ph25 = 0, m_coil = 0, m_lim = 0, m_zcq = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_sync <= 2'b00;
    else        m_sync <= {m_sync[0], 1'b1};
  end

  always @(posedge clk) begin
    int rise, s, nr, nra, na, naa, np, nc, nl;
    if (!m_sync[1]) begin
      m_ramp = 0; m_racc = 0; m_adp = 0; m_aacc = 0;
      m_ph25 = 0; m_coil = 0; m_lim = 0; m_zcq = 0;
    end else begin
      rise = (zc && !m_zcq) ? 1 : 0;
      nr = m_ramp;
      s = m_racc + (m_ph25 ? RDN : RUP);
      nra = s % FMOD;
      if (s >= FMOD) begin
        if (m_ph25) nr = (m_ramp > 0) ? m_ramp - 1 : 0;
        else        nr = (m_ramp < CMAX) ? m_ramp + 1 : CMAX;
      end
      na = m_adp; naa = m_aacc;
      if (st) begin
        na = 0; naa = 0;
      end else if (m_ph25) begin
        s = m_aacc + (hi ? ADNH : ADN);
        naa = s % FMOD;
        if (s >= FMOD && m_adp > 0) na = m_adp - 1;
      end else if (m_lim) begin
        s = m_aacc + AUP;
        naa = s % FMOD;
        if (s >= FMOD && m_adp < CMAX) na = m_adp + 1;
      end
      np = rise ? 1 : ((m_ph25 && m_ramp <= REFL) ? 0 : m_ph25);
      nl = rise ? 0 : ((m_lim || (m_coil && cur_lim)) ? 1 : 0);
      nc = (ovp || rise) ? 0 : ((!m_ph25 && m_ramp > m_adp) ? 1 : m_coil);
      m_ramp = nr; m_racc = nra; m_adp = na; m_aacc = naa;
      m_ph25 = np; m_lim = nl; m_coil = nc; m_zcq = zc ? 1 : 0;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: coil_on=%0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic step(input logic zc_v, input logic hi_v, input logic ovp_v, input logic st_v);
    @(negedge clk);
    chk(int'(coil_on) == m_coil, cur_req, int'(coil_on), m_coil);
    if (pend_ovp)  chk(coil_on == 1'b0, "R9", int'(coil_on), 0);
    if (pend_rise) chk(coil_on == 1'b0, "R2", int'(coil_on), 0);
    if (m_coil != 0) model_on_cycles++;
    pend_ovp  = ovp_v;
    pend_rise = zc_v && !zc;
    coil_run  = coil_on ? coil_run + 1 : 0;
    cur_lim   = (coil_run >= lim_dly);
    zc = zc_v; hi = hi_v; ovp = ovp_v; st = st_v;
  endtask

  task automatic run(input int period, input int ncyc, input logic hi_v,
                     input logic st_v, input int ovp_at);
    for (int c = 0; c < ncyc; c++) begin
      for (int i = 0; i < period; i++) begin
        step(i < period / 2, hi_v, (i == ovp_at), st_v);
      end
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(coil_on == 1'b0, "R1", int'(coil_on), 0);
    end
    rst_n = 1'b1;
    cur_req = "R1";
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 1'b0, 1'b0);

    cur_req = "R8";
    run(300, 4, 1'b0, 1'b1, -1);

    cur_req = "R6";
    for (int d = 0; d < 2; d++) begin
      lim_dly = (d == 0) ? 5 : 20;
      for (int h = 0; h < 2; h++) begin
        cur_req = (h == 0) ? "R6" : "R5";
        for (int p = 80; p <= 400; p += 80) run(p, 5, logic'(h), 1'b0, -1);
      end
    end
    chk(model_on_cycles > 0, "R7", (model_on_cycles > 0) ? 1 : 0, 1);

    cur_req = "R9";
    lim_dly = 8;
    run(240, 3, 1'b0, 1'b0, 200);

    cur_req = "R11";
    for (int i = 0; i < 900; i++) step(1'b1, 1'b0, 1'b0, 1'b0);
    run(200, 3, 1'b0, 1'b0, -1);

    cur_req = "R10";
    run(1400, 3, 1'b0, 1'b0, -1);
    run(60, 6, 1'b1, 1'b0, -1);

    cur_req = "R4";
    run(120, 4, 1'b0, 1'b0, -1);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule